// File: doc/BRIEF.md
# Memory wait-state and bank select generator

This controller sits between a processor's external memory port and two SRAM banks. It is clocked by the processor's clock output and watches the active-low memory cycle strobe together with the three highest address lines. From these it derives two active-low bank chip-enables, a pair of block indicator bits and a wait request that stretches each external access.

The access length comes from two strap-style select bits, where a fitted strap reads as 0. A saturating counter is cleared while the strobe is high and advances on every clock edge while it is low. Three tap outputs rise one, two and three edges into an access. The wait request is raised as soon as the strobe falls. It is released when the tap matching the requested number of inserted wait cycles rises, which gives accesses of 2, 3, 4 or 5 clocks.

A two-bit map input sets how the 64 KB address space is divided between the upper and the lower SRAM.

Top module: `memwait_gen`

## Requirements
- R1: While reset is applied, and afterwards while `mem_ce_n` is high, `tap_o` is 3'b000, `wait_o` is 0, both bank enables are 1 and `blk_o` equals `addr_hi[2:1]`.
- R2: `tap_o[n-1]` (n = 1..3) is 1 from the n-th rising clock edge that samples `mem_ce_n` low until `mem_ce_n` goes high, and is 0 otherwise. The taps always form a thermometer code.
- R3: `wait_sel[1:0]` sets W, the number of inserted wait cycles: 2'b00 gives W=0 (2-clock access), 2'b10 gives W=1 (3 clocks), 2'b01 gives W=2 (4 clocks) and 2'b11 gives W=3 (5 clocks).
- R4: `wait_o` is 1 combinationally as soon as `mem_ce_n` is low and W>0. It stays 1 until the W-th edge of the access, so it is seen high for exactly W clocks, and it is never 1 while `mem_ce_n` is high.
- R5: With `map_sel`=2'b00, A15 (`addr_hi[2]`) selects the bank: 0 enables `lo_ce_n` and 1 enables `hi_ce_n`.
- R6: With `map_sel`=2'b01 or 2'b10, both banks lie in the lower 32 KB. A14 (`addr_hi[1]`)=0 enables `lo_ce_n`, A14=1 enables `hi_ce_n`, and A15=1 enables neither.
- R7: With `map_sel`=2'b11, both banks lie in the lower 16 KB. A13 (`addr_hi[0]`) picks lower or upper bank, and any address with A15 or A14 set enables neither.
- R8: `lo_ce_n` and `hi_ce_n` are never 0 at the same time, and both are 1 while `mem_ce_n` is high.
- R9: `blk_o` shows `addr_hi[2:1]` until the first edge of an access. From that edge until `mem_ce_n` goes high, it holds the value captured there, even if the address changes.
- R10: An access that starts after `mem_ce_n` has been high for at least one edge restarts the count from zero, so back-to-back accesses each get their full wait length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock output |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_ce_n | input | 1 | Active-low memory cycle strobe |
| addr_hi | input | 3 | Address lines A15, A14, A13 (bit 2 = A15) |
| wait_sel | input | 2 | Wait-length straps, fitted = 0 |
| map_sel | input | 2 | Address map selection |
| lo_ce_n | output | 1 | Lower SRAM chip-enable, active low |
| hi_ce_n | output | 1 | Upper SRAM chip-enable, active low |
| blk_o | output | 2 | Block indicator, A15:A14 of the current access |
| tap_o | output | 3 | Delay taps, bit n-1 = n cycles into the access |
| wait_o | output | 1 | Selected wait request to the processor |

## Verification
The wait release and the block capture both fall on the first clock edge of an access when W=1. The same edge also moves the bank enables whenever the address changes during the access. The bench provokes this by running one-wait accesses in which the address is changed after the first edge. A behavioural model compares wait, taps, block bits and bank enables on every falling clock edge. Separate checks count the wait-high cycles of each access against the length that the select code calls for.

// File: rtl/memwait_pkg.sv
package memwait_pkg;
  localparam int WSEL_W   = 2;
  localparam int MAX_WAIT = (1 << WSEL_W) - 1;
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);

  // Straps read 0 when fitted; the mapping onto wait cycles is non-binary.
  function automatic logic [CNT_W-1:0] wait_count(input logic [WSEL_W-1:0] sel);
    case (sel)
      2'b00:   wait_count = CNT_W'(0);
      2'b10:   wait_count = CNT_W'(1);
      2'b01:   wait_count = CNT_W'(2);
      default: wait_count = CNT_W'(3);
    endcase
  endfunction

  // Returns {upper, lower} bank hits, active high, before strobe gating.
  function automatic logic [1:0] bank_hit(input logic [1:0] map, input logic [2:0] a);
    logic a15, a14, a13;
    a15 = a[2]; a14 = a[1]; a13 = a[0];
    case (map)
      2'b00:        bank_hit = {a15, ~a15};
      2'b01, 2'b10: bank_hit = {~a15 & a14, ~a15 & ~a14};
      default:      bank_hit = {~a15 & ~a14 & a13, ~a15 & ~a14 & ~a13};
    endcase
  endfunction
endpackage

// File: rtl/mw_tap_chain.sv
module mw_tap_chain #(
  parameter int TAPS  = memwait_pkg::MAX_WAIT,
  parameter int CNT_W = memwait_pkg::CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  output logic [CNT_W-1:0] cnt_o,
  output logic [TAPS-1:0]  tap_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (!active)                cnt_q <= '0;
    else if (cnt_q != CNT_W'(TAPS))  cnt_q <= cnt_q + CNT_W'(1);
  end

  genvar i;
  generate
    for (i = 0; i < TAPS; i++) begin : g_tap
      assign tap_o[i] = active & (cnt_q >= CNT_W'(i + 1));
    end
  endgenerate

  assign cnt_o = cnt_q;

  p_tap_thermo_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_o[2] |-> tap_o[1]) and (tap_o[1] |-> tap_o[0]));

  p_tap1_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(active) && active) |-> tap_o[0]);

  p_tap_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (tap_o == '0));
endmodule

// File: rtl/mw_wait_select.sv
module mw_wait_select #(
  parameter int TAPS   = memwait_pkg::MAX_WAIT,
  parameter int WSEL_W = memwait_pkg::WSEL_W,
  parameter int CNT_W  = memwait_pkg::CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic [WSEL_W-1:0] wait_sel,
  input  logic [TAPS-1:0]   tap_i,
  output logic              wait_o
);
  logic [CNT_W-1:0] need;
  logic             reached;

  assign need = memwait_pkg::wait_count(wait_sel);

  always_comb begin
    reached = 1'b1;
    for (int k = 1; k <= TAPS; k++) begin
      if (need == CNT_W'(k)) reached = tap_i[k-1];
    end
  end

  assign wait_o = active & ~reached;

  p_no_wait_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !wait_o);

  p_wait_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && tap_i[TAPS-1]) |-> !wait_o);
endmodule

// File: rtl/mw_bank_decode.sv
module mw_bank_decode (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  logic [1:0] map_sel,
  input  logic [2:0] addr_hi,
  output logic       lo_ce_n,
  output logic       hi_ce_n
);
  logic [1:0] hit;

  assign hit     = memwait_pkg::bank_hit(map_sel, addr_hi);
  assign lo_ce_n = ~(active & hit[0]);
  assign hi_ce_n = ~(active & hit[1]);

  p_bank_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(!lo_ce_n && !hi_ce_n));

  p_bank_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (lo_ce_n && hi_ce_n));
endmodule

// File: rtl/memwait_gen.sv
module memwait_gen #(
  parameter int WSEL_W = memwait_pkg::WSEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_ce_n,
  input  logic [2:0]        addr_hi,
  input  logic [WSEL_W-1:0] wait_sel,
  input  logic [1:0]        map_sel,
  output logic              lo_ce_n,
  output logic              hi_ce_n,
  output logic [1:0]        blk_o,
  output logic [2:0]        tap_o,
  output logic              wait_o
);
  localparam int TAPS  = (1 << WSEL_W) - 1;
  localparam int CNT_W = $clog2(TAPS + 1);

  logic             active;
  logic [CNT_W-1:0] cnt;
  logic             first_cycle;
  logic             holding;
  logic [1:0]       blk_q;

  assign active      = ~mem_ce_n;
  assign first_cycle = active & (cnt == '0);
  assign holding     = active & (cnt != '0);

  mw_tap_chain #(.TAPS(TAPS), .CNT_W(CNT_W)) u_taps (
    .clk(clk), .rst_n(rst_n), .active(active), .cnt_o(cnt), .tap_o(tap_o)
  );

  mw_wait_select #(.TAPS(TAPS), .WSEL_W(WSEL_W), .CNT_W(CNT_W)) u_wsel (
    .clk(clk), .rst_n(rst_n), .active(active), .wait_sel(wait_sel),
    .tap_i(tap_o), .wait_o(wait_o)
  );

  mw_bank_decode u_bank (
    .clk(clk), .rst_n(rst_n), .active(active), .map_sel(map_sel),
    .addr_hi(addr_hi), .lo_ce_n(lo_ce_n), .hi_ce_n(hi_ce_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           blk_q <= 2'b00;
    else if (first_cycle) blk_q <= addr_hi[2:1];
  end

  assign blk_o = holding ? blk_q : addr_hi[2:1];

  p_blk_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (holding && $past(holding)) |-> $stable(blk_o));

  p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ce_n |=> (tap_o == '0 || !mem_ce_n) && !tap_o[1]);
endmodule

// File: tb/sim_memwait_gen.sv
module sim_memwait_gen;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mem_ce_n = 1'b1;
  logic [2:0] addr_hi = 3'b000;
  logic [1:0] wait_sel = 2'b00;
  logic [1:0] map_sel = 2'b00;
  logic       lo_ce_n, hi_ce_n, wait_o;
  logic [1:0] blk_o;
  logic [2:0] tap_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  int         ref_cnt = 0;
  logic [1:0] ref_blk = 2'b00;

  always #(CLK_PERIOD/2) clk = ~clk;

  memwait_gen u0 (
    .clk(clk), .rst_n(rst_n), .mem_ce_n(mem_ce_n), .addr_hi(addr_hi),
    .wait_sel(wait_sel), .map_sel(map_sel), .lo_ce_n(lo_ce_n),
    .hi_ce_n(hi_ce_n), .blk_o(blk_o), .tap_o(tap_o), .wait_o(wait_o)
  );

  function automatic int waits_for(input logic [1:0] s);
    if (s == 2'b00) return 0;
    if (s == 2'b10) return 1;
    if (s == 2'b01) return 2;
    return 3;
  endfunction

  function automatic logic [1:0] exp_banks(input logic ce_n, input logic [1:0] m,
                                           input logic [2:0] a);
    int addr;
    int lim;
    addr = a[2] * 32768 + a[1] * 16384 + a[0] * 8192;
    if (ce_n) return 2'b11;
    if (m == 2'b00) lim = 65536;
    else if (m == 2'b11) lim = 16384;
    else lim = 32768;
    if (addr >= lim) return 2'b11;
    if (addr < lim / 2) return 2'b10;  // {hi_ce_n, lo_ce_n}: lower bank on
    return 2'b01;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model: counts clock edges with the strobe low.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_cnt = 0;
      ref_blk = 2'b00;
    end else if (mem_ce_n) begin
      ref_cnt = 0;
    end else begin
      if (ref_cnt == 0) ref_blk = addr_hi[2:1];
      if (ref_cnt < 3) ref_cnt = ref_cnt + 1;
    end
  end

  // Compare on every falling edge.
  always @(negedge clk) begin
    if (rst_n) begin
      int w;
      int exp_tap;
      w = waits_for(wait_sel);
      exp_tap = mem_ce_n ? 0 : ((1 << ref_cnt) - 1);
      check("R2 taps", tap_o, exp_tap);
      check("R4 wait", wait_o, (!mem_ce_n && ref_cnt < w) ? 1 : 0);
      check("R5/R6/R7/R8 banks", {hi_ce_n, lo_ce_n}, exp_banks(mem_ce_n, map_sel, addr_hi));
      check("R9 blk", blk_o, (!mem_ce_n && ref_cnt != 0) ? ref_blk : addr_hi[2:1]);
    end
  end

  // One access: strobe low for len falling edges; counts wait-high samples.
  task automatic access(input logic [1:0] s, input logic [1:0] m, input logic [2:0] a,
                        input int len, input bit move_addr, input bit back2back);
    int seen = 0;
    @(posedge clk); #1;
    wait_sel = s; map_sel = m; addr_hi = a; mem_ce_n = 1'b0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (wait_o) seen++;
      if (move_addr && i == 1) addr_hi = ~a;
    end
    check(back2back ? "R10 restart length" : "R3 access length", seen + 2, waits_for(s) + 2);
    @(posedge clk); #1;
    mem_ce_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 tap reset", tap_o, 0);
    check("R1 wait reset", wait_o, 0);
    check("R1 banks reset", {hi_ce_n, lo_ce_n}, 3);
    check("R1 blk reset", blk_o, 0);
    @(posedge clk); #1; rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3: every select code, each map code, several addresses
    for (int s = 0; s < 4; s++)
      for (int m = 0; m < 4; m++)
        for (int a = 0; a < 8; a += 3)
          access(2'(s), 2'(m), 3'(a), 6, 0, 0);

    // R9: address moves mid-access, with the one-wait code where release and capture share an edge
    access(2'b10, 2'b00, 3'b010, 5, 1, 0);
    access(2'b11, 2'b01, 3'b001, 5, 1, 0);
    access(2'b01, 2'b11, 3'b100, 5, 1, 0);

    // R10: back-to-back accesses with a single idle edge between them
    for (int s = 0; s < 4; s++) begin
      access(2'(s), 2'b00, 3'b111, 5, 0, 1);
      access(2'(s), 2'b10, 3'b011, 5, 0, 1);
    end

    // R4: wait visible before any edge once the strobe falls
    @(posedge clk); #1;
    wait_sel = 2'b11; mem_ce_n = 1'b0; #1;
    check("R4 early wait", wait_o, 1);
    @(posedge clk); #1; mem_ce_n = 1'b1; #1;
    check("R4 idle wait", wait_o, 0);
    check("R1 idle taps", tap_o, 0);

    repeat (2) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule